// File: doc/BRIEF.md
# Section Address Translator with Domain Check

This block turns 32-bit virtual addresses into physical addresses using a single-level table of 1 MB section descriptors held in memory. A small fully associative translation buffer sits in front of a hardware walker. On a buffer miss, the walker fetches one descriptor over a memory read port. It builds the physical address from the descriptor and returns it together with cacheable and bufferable attributes. If the lookup fails, it returns an abort instead.

Access rights come from a per-domain two-bit code and not from any bit in the entry. Each descriptor names one of sixteen domains, and a control word gives the code for each domain. An abort records an eight-bit status and the faulting virtual address. The status carries the domain number in its upper nibble and the fault kind in its lower nibble. When translation is switched off, every address passes through unchanged. Software must flush the buffer whenever it edits a table entry.

Top module: `sectMmu`

## Requirements
- R1: After reset, reqReady is 1, rspValid and memReqValid are 0, and faultStatus, faultAddr and faultWrite are 0.
- R2: With ctlEnable low, a request gets rspPa equal to reqVa with rspAbort, rspCacheable and rspBufferable all 0, one cycle after acceptance. No memory read is made and the fault registers keep their values.
- R3: On a miss the walker holds memReqValid until memRspValid arrives, with memAddr = ctlBase OR (reqVa[31:20] shifted left by 2). reqReady stays low for the whole walk.
- R4: A descriptor with bits [1:0] = 2'b10 is a section. rspPa = {desc[31:20], reqVa[19:0]}, rspCacheable = desc[3] and rspBufferable = desc[2]. The response comes one cycle after memRspValid.
- R5: The descriptor's domain is desc[8:5], and its code is ctlDomains[2d+1:2d]. Codes 2'b01 and 2'b11 let the access through. Codes 2'b00 and 2'b10 abort with faultStatus = {domain, 4'h9}.
- R6: A descriptor whose bits [1:0] are not 2'b10 aborts with faultStatus = 8'h05.
- R7: Every abort loads faultAddr with the virtual address and faultWrite with reqWrite. A response that is not an abort leaves faultStatus, faultAddr and faultWrite unchanged.
- R8: An abort response carries rspPa = 0 and rspCacheable = rspBufferable = 0.
- R9: A request that hits a cached section responds one cycle after acceptance without a memory read. The hit is checked against the current ctlDomains, so revoking a domain aborts a cached section.
- R10: Descriptors that produce an abort are not cached, so repeating the access walks again.
- R11: The buffer holds 8 entries and replaces them in round-robin order. With all 8 in use, the ninth fill evicts the oldest fill.
- R12: Raising ctlTlbFlush for one cycle empties the buffer. A request accepted in that cycle is treated as a miss, and a walk that completes in that cycle is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Request accepted this cycle when high |
| reqVa | input | 32 | Virtual address |
| reqWrite | input | 1 | Access is a write |
| rspValid | output | 1 | One-cycle response strobe |
| rspPa | output | 32 | Physical address |
| rspCacheable | output | 1 | Section may be cached |
| rspBufferable | output | 1 | Section may be write-buffered |
| rspAbort | output | 1 | Access aborted |
| memReqValid | output | 1 | Descriptor read pending |
| memAddr | output | 32 | Descriptor byte address |
| memRspValid | input | 1 | Descriptor data valid |
| memRdata | input | 32 | Descriptor word |
| ctlBase | input | 32 | Table base, low 14 bits zero |
| ctlDomains | input | 32 | Two-bit access code per domain |
| ctlEnable | input | 1 | Translation on |
| ctlTlbFlush | input | 1 | Invalidate all buffer entries |
| faultStatus | output | 8 | {domain, fault code} of last abort |
| faultAddr | output | 32 | Virtual address of last abort |
| faultWrite | output | 1 | Direction of last abort |

## Verification
A flush can land in the same cycle as a buffer lookup, and it can land in the same cycle as a walker fill. The bench provokes the first by raising the flush alongside a request whose section is already cached. The design passes if that request still makes a memory read. It provokes the second by arming the memory model to pulse the flush together with the descriptor data. The design passes if the response is still correct and the next access to that section walks again. A reference model of the buffer contents in the bench predicts every hit and miss. That prediction is checked against the count of memory reads and the response latency.

// File: rtl/mmuPkg.sv
package mmuPkg;
  localparam int VA_W     = 32;
  localparam int SECT_W   = 20;
  localparam int TAG_W    = VA_W - SECT_W;
  localparam int DOM_W    = 4;
  localparam int NUM_DOM  = 1 << DOM_W;
  localparam int DACR_W   = 2 * NUM_DOM;

  localparam logic [3:0] FS_DOMAIN = 4'h9;
  localparam logic [3:0] FS_XLATE  = 4'h5;
  localparam logic [1:0] DESC_SECTION = 2'b10;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] vTag;
    logic [TAG_W-1:0] pTag;
    logic [DOM_W-1:0] dom;
    logic             cach;
    logic             buff;
  } tlbEntry_t;

  typedef struct packed {
    logic accept;
    logic finishDirect;
    logic finishWalk;
  } ctlStrobe_t;

  typedef enum logic {ST_IDLE, ST_WALK} walkState_t;

  function automatic logic domainPasses(input logic [1:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/mmuTlb.sv
module mmuTlb
  import mmuPkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic             flush,
  input  logic             fillEn,
  input  tlbEntry_t        fillEntry,
  output logic             hit,
  output tlbEntry_t        hitEntry
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbEntry_t entries [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] validVec;
  logic [PTR_W-1:0] ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign validVec[g] = entries[g].valid;
    assign hitVec[g]   = entries[g].valid && (entries[g].vTag == lookupTag);
  end

  always_comb begin
    hitEntry = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitEntry = hitEntry | entries[i];
    end
  end

  // a flush in the same cycle hides every entry from the lookup
  assign hit = (|hitVec) && !flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entries[i] <= '0;
      ptr <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) entries[i].valid <= 1'b0;
    end else if (fillEn) begin
      entries[ptr] <= fillEntry;
      ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  a_r11_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r12_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0));
endmodule

// File: rtl/mmuCtrl.sv
module mmuCtrl
  import mmuPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ctlEnable,
  input  logic       tlbHit,
  input  logic       memRspValid,
  output logic       reqReady,
  output logic       memReqValid,
  output ctlStrobe_t strobe
);
  walkState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.accept = 1'b1;
          if (!ctlEnable || tlbHit) strobe.finishDirect = 1'b1;
          else                      stateNext = ST_WALK;
        end
      end
      ST_WALK: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          strobe.finishWalk = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  a_r3_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> memReqValid);

  a_r3_walk_follows_miss: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && ctlEnable && !tlbHit) |=> memReqValid);
endmodule

// File: rtl/mmuDatapath.sv
module mmuDatapath
  import mmuPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqWrite,
  input  logic              ctlEnable,
  input  logic [DACR_W-1:0] ctlDomains,
  input  logic [VA_W-1:0]   ctlBase,
  input  logic [VA_W-1:0]   memRdata,
  input  tlbEntry_t         hitEntry,
  output logic [VA_W-1:0]   memAddr,
  output logic              fillEn,
  output tlbEntry_t         fillEntry,
  output logic              rspValid,
  output logic [VA_W-1:0]   rspPa,
  output logic              rspCacheable,
  output logic              rspBufferable,
  output logic              rspAbort,
  output logic [7:0]        faultStatus,
  output logic [VA_W-1:0]   faultAddr,
  output logic              faultWrite
);
  logic [VA_W-1:0] vaQ;
  logic            writeQ;

  logic [DOM_W-1:0] descDom;
  logic [1:0]       descCode;
  logic             descSection;
  logic             descPass;
  logic [1:0]       hitCode;
  logic             unusedDescBits;

  logic            resAbort, resC, resB, resWrite, finishAny;
  logic [VA_W-1:0] resPa, resVa;
  logic [7:0]      resStatus;

  assign memAddr = ctlBase | {{(VA_W-TAG_W-2){1'b0}}, vaQ[VA_W-1 -: TAG_W], 2'b00};

  assign descDom     = memRdata[8:5];
  assign descCode    = ctlDomains[{descDom, 1'b0} +: 2];
  assign descSection = (memRdata[1:0] == DESC_SECTION);
  assign descPass    = domainPasses(descCode);
  assign hitCode     = ctlDomains[{hitEntry.dom, 1'b0} +: 2];
  assign unusedDescBits = ^{memRdata[SECT_W-1:9], memRdata[4], hitEntry.valid, hitEntry.vTag};

  assign fillEn = strobe.finishWalk && descSection && descPass;
  always_comb begin
    fillEntry       = '0;
    fillEntry.valid = 1'b1;
    fillEntry.vTag  = vaQ[VA_W-1 -: TAG_W];
    fillEntry.pTag  = memRdata[VA_W-1 -: TAG_W];
    fillEntry.dom   = descDom;
    fillEntry.cach  = memRdata[3];
    fillEntry.buff  = memRdata[2];
  end

  assign finishAny = strobe.finishDirect || strobe.finishWalk;

  always_comb begin
    resAbort  = 1'b0;
    resPa     = '0;
    resC      = 1'b0;
    resB      = 1'b0;
    resStatus = '0;
    if (strobe.finishWalk) begin
      resVa    = vaQ;
      resWrite = writeQ;
      if (!descSection) begin
        resAbort  = 1'b1;
        resStatus = {4'h0, FS_XLATE};
      end else if (!descPass) begin
        resAbort  = 1'b1;
        resStatus = {descDom, FS_DOMAIN};
      end else begin
        resPa = {memRdata[VA_W-1 -: TAG_W], vaQ[SECT_W-1:0]};
        resC  = memRdata[3];
        resB  = memRdata[2];
      end
    end else begin
      resVa    = reqVa;
      resWrite = reqWrite;
      if (!ctlEnable) begin
        resPa = reqVa;
      end else if (!domainPasses(hitCode)) begin
        resAbort  = 1'b1;
        resStatus = {hitEntry.dom, FS_DOMAIN};
      end else begin
        resPa = {hitEntry.pTag, reqVa[SECT_W-1:0]};
        resC  = hitEntry.cach;
        resB  = hitEntry.buff;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ           <= '0;
      writeQ        <= 1'b0;
      rspValid      <= 1'b0;
      rspPa         <= '0;
      rspCacheable  <= 1'b0;
      rspBufferable <= 1'b0;
      rspAbort      <= 1'b0;
      faultStatus   <= '0;
      faultAddr     <= '0;
      faultWrite    <= 1'b0;
    end else begin
      rspValid <= finishAny;
      if (strobe.accept) begin
        vaQ    <= reqVa;
        writeQ <= reqWrite;
      end
      if (finishAny) begin
        rspPa         <= resPa;
        rspCacheable  <= resC;
        rspBufferable <= resB;
        rspAbort      <= resAbort;
        if (resAbort) begin
          faultStatus <= resStatus;
          faultAddr   <= resVa;
          faultWrite  <= resWrite;
        end
      end
    end
  end

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAbort) |-> (rspPa[SECT_W-1:0] == vaQ[SECT_W-1:0]));

  a_r8_abort_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAbort) |-> (rspPa == '0 && !rspCacheable && !rspBufferable));

  a_r7_fault_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAbort) |-> (faultAddr == vaQ));

  a_r6_fault_code: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAbort) |-> (faultStatus[3:0] == FS_XLATE || faultStatus[3:0] == FS_DOMAIN));

  a_r2_identity: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.finishDirect && !ctlEnable) |-> (rspPa == vaQ && !rspAbort));
endmodule

// File: rtl/sectMmu.sv
module sectMmu
  import mmuPkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVa,
  input  logic        reqWrite,
  output logic        rspValid,
  output logic [31:0] rspPa,
  output logic        rspCacheable,
  output logic        rspBufferable,
  output logic        rspAbort,
  output logic        memReqValid,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRdata,
  input  logic [31:0] ctlBase,
  input  logic [31:0] ctlDomains,
  input  logic        ctlEnable,
  input  logic        ctlTlbFlush,
  output logic [7:0]  faultStatus,
  output logic [31:0] faultAddr,
  output logic        faultWrite
);
  ctlStrobe_t strobe;
  logic       tlbHit;
  logic       fillEn;
  tlbEntry_t  hitEntry;
  tlbEntry_t  fillEntry;

  mmuCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctlEnable(ctlEnable),
    .tlbHit(tlbHit), .memRspValid(memRspValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .strobe(strobe)
  );

  mmuTlb #(.ENTRIES(TLB_ENTRIES)) uTlb (
    .clk(clk), .rstN(rstN), .lookupTag(reqVa[VA_W-1 -: TAG_W]),
    .flush(ctlTlbFlush), .fillEn(fillEn), .fillEntry(fillEntry),
    .hit(tlbHit), .hitEntry(hitEntry)
  );

  mmuDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVa(reqVa), .reqWrite(reqWrite),
    .ctlEnable(ctlEnable), .ctlDomains(ctlDomains), .ctlBase(ctlBase),
    .memRdata(memRdata), .hitEntry(hitEntry), .memAddr(memAddr),
    .fillEn(fillEn), .fillEntry(fillEntry), .rspValid(rspValid), .rspPa(rspPa),
    .rspCacheable(rspCacheable), .rspBufferable(rspBufferable), .rspAbort(rspAbort),
    .faultStatus(faultStatus), .faultAddr(faultAddr), .faultWrite(faultWrite)
  );
endmodule

// File: tb/tb_sectMmu.sv
module tb_sectMmu;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 8;
  localparam logic [31:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [31:0] reqVa = '0;
  logic rspValid, rspCacheable, rspBufferable, rspAbort;
  logic [31:0] rspPa;
  logic memReqValid, memRspValid = 1'b0;
  logic [31:0] memAddr, memRdata = '0;
  logic [31:0] ctlBase = BASE, ctlDomains = 32'hFFFF_FFFF;
  logic ctlEnable = 1'b0, ctlTlbFlush;
  logic flushReq = 1'b0, flushFill = 1'b0;
  logic [7:0] faultStatus;
  logic [31:0] faultAddr;
  logic faultWrite;

  assign ctlTlbFlush = flushReq | flushFill;

  sectMmu dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int walkCount = 0, memLat = 0, waitCnt = 0;
  bit flushArm = 1'b0, finished = 1'b0;
  logic [31:0] curVa = '0;

  logic [11:0] mTag [NENT];
  bit mValid [NENT];
  int mPtr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] typeFor(input logic [11:0] idx);
    if (idx % 7 == 3) return 2'b00;
    if (idx % 11 == 5) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [31:0] descFor(input logic [11:0] idx);
    return {idx ^ 12'h5A3, 11'd0, idx[3:0], 1'b0, idx[4], idx[5], typeFor(idx)};
  endfunction

  function automatic bit modelHit(input logic [11:0] idx);
    for (int i = 0; i < NENT; i++) if (mValid[i] && mTag[i] == idx) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < NENT; i++) mValid[i] = 1'b0;
  endtask

  // memory model: answers a pending read after memLat idle cycles
  initial forever begin
    @(negedge clk);
    flushFill = 1'b0;
    if (memRspValid) memRspValid = 1'b0;
    else if (memReqValid) begin
      if (waitCnt == memLat) begin
        chk(memAddr == (BASE | {18'd0, curVa[31:20], 2'b00}), "R3 descriptor address", memAddr,
            BASE | {18'd0, curVa[31:20], 2'b00});
        chk(reqReady == 1'b0, "R3 ready low during walk", {31'd0, reqReady}, 32'd0);
        memRdata = descFor(memAddr[13:2]);
        memRspValid = 1'b1;
        walkCount++;
        waitCnt = 0;
        if (flushArm) flushFill = 1'b1;
      end else waitCnt++;
    end
  end

  task automatic access(input logic [31:0] va, input bit flushNow, input bit flushAtFill, input string tag);
    logic [11:0] idx;
    logic [31:0] d, expPa;
    logic [7:0] expSt, oldSt;
    logic [31:0] oldAddr;
    logic oldW, expAbort, expC, expB, hit, wr;
    logic [1:0] code;
    int walksBefore, lat;
    idx = va[31:20];
    d = descFor(idx);
    wr = va[0] ^ va[5];
    expPa = '0; expAbort = 1'b0; expC = 1'b0; expB = 1'b0; expSt = '0; hit = 1'b0;
    if (!ctlEnable) expPa = va;
    else begin
      hit = !flushNow && modelHit(idx);
      code = ctlDomains[{d[8:5], 1'b0} +: 2];
      if (d[1:0] != 2'b10) begin expAbort = 1'b1; expSt = 8'h05; end
      else if (!code[0]) begin expAbort = 1'b1; expSt = {d[8:5], 4'h9}; end
      else begin expPa = {d[31:20], va[19:0]}; expC = d[3]; expB = d[2]; end
    end
    walksBefore = walkCount;
    oldSt = faultStatus; oldAddr = faultAddr; oldW = faultWrite;
    @(negedge clk);
    curVa = va; reqVa = va; reqWrite = wr; reqValid = 1'b1;
    flushReq = flushNow; flushArm = flushAtFill;
    @(negedge clk);
    reqValid = 1'b0; flushReq = 1'b0;
    lat = 1;
    while (!rspValid && lat < 60) begin @(negedge clk); lat++; end
    flushArm = 1'b0;
    chk(rspValid, {tag, " response"}, {31'd0, rspValid}, 32'd1);
    chk(rspPa == expPa, {tag, " pa"}, rspPa, expPa);
    chk({rspAbort, rspCacheable, rspBufferable} == {expAbort, expC, expB}, {tag, " abort/C/B"},
        {29'd0, rspAbort, rspCacheable, rspBufferable}, {29'd0, expAbort, expC, expB});
    if (!ctlEnable || hit) begin
      chk(walkCount == walksBefore, {tag, " no memory read"}, walkCount, walksBefore);
      chk(lat == 1, {tag, " one-cycle latency"}, lat, 1);
    end else begin
      chk(walkCount == walksBefore + 1, {tag, " one memory read"}, walkCount, walksBefore + 1);
      chk(lat == memLat + 2, {tag, " walk latency"}, lat, memLat + 2);
    end
    if (expAbort) begin
      chk(faultStatus == expSt, {tag, " R7 status"}, {24'd0, faultStatus}, {24'd0, expSt});
      chk(faultAddr == va && faultWrite == wr, {tag, " R7 fault addr/dir"}, faultAddr, va);
    end else
      chk(faultStatus == oldSt && faultAddr == oldAddr && faultWrite == oldW,
          {tag, " R7 fault regs kept"}, faultAddr, oldAddr);
    if (ctlEnable) begin
      if (flushNow) modelClear();
      if (!hit && !expAbort && !flushAtFill) begin
        mTag[mPtr] = idx; mValid[mPtr] = 1'b1; mPtr = (mPtr + 1) % NENT;
      end
      if (flushAtFill) modelClear();
    end
  endtask

  function automatic logic [31:0] vaOf(input int idx);
    return {12'(idx), 20'(idx * 12345 + 7)};
  endfunction

  function automatic int nextSect(input int from);
    int i = from;
    while (typeFor(12'(i)) != 2'b10) i++;
    return i;
  endfunction

  initial begin
    int s [NENT+1];
    int k;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1 && rspValid == 0 && memReqValid == 0, "R1 handshake at reset",
        {29'd0, reqReady, rspValid, memReqValid}, 32'h4);
    chk(faultStatus == 0 && faultAddr == 0 && faultWrite == 0, "R1 fault regs at reset", faultAddr, 0);

    // R2: translation off
    for (int i = 0; i < 16; i++) access(vaOf(i * 257 + 3), 1'b0, 1'b0, "R2 bypass");

    // R3 R4 R6: walks with all domains open, memory latency varied
    ctlEnable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      memLat = i % 3;
      access(vaOf(i), 1'b0, 1'b0, "R4 R6 walk");
    end
    // R5: mixed domain codes, cached and uncached
    ctlDomains = 32'h1B4E_93C6;
    for (int i = 40; i < 72; i++) begin
      memLat = i % 4;
      access(vaOf(i), 1'b0, 1'b0, "R5 domain");
    end
    // R9 R10: revisit recent sections, hits and refetches per model
    for (int i = 56; i < 72; i++) access(vaOf(i) ^ 32'h0000_0F0F, 1'b0, 1'b0, "R9 R10 revisit");

    // R11: round robin
    memLat = 1;
    ctlDomains = 32'hFFFF_FFFF;
    access(vaOf(200), 1'b1, 1'b0, "R12 flush before fill");
    k = 300;
    for (int i = 0; i <= NENT; i++) begin k = nextSect(k); s[i] = k; k++; end
    access(vaOf(s[0]), 1'b1, 1'b0, "R11 first fill");
    for (int i = 1; i <= NENT; i++) access(vaOf(s[i]), 1'b0, 1'b0, "R11 fill");
    chk(!modelHit(12'(s[0])) && modelHit(12'(s[1])), "R11 model eviction", 0, 0);
    access(vaOf(s[2]), 1'b0, 1'b0, "R11 survivor hit");
    access(vaOf(s[0]), 1'b0, 1'b0, "R11 oldest evicted");

    // R9: revoke a cached section's domain
    ctlDomains = ~(32'h3 << (2 * (s[2] % 16)));
    access(vaOf(s[2]), 1'b0, 1'b0, "R9 revoked hit");
    ctlDomains = 32'hFFFF_FFFF;
    access(vaOf(s[3]), 1'b0, 1'b0, "R9 hit");

    // R12: flush with accepted hit, and flush with a fill
    access(vaOf(s[3]), 1'b1, 1'b0, "R12 flush with lookup");
    access(vaOf(s[3]), 1'b0, 1'b0, "R12 refilled hit");
    access(vaOf(s[5]), 1'b0, 1'b1, "R12 flush with fill");
    access(vaOf(s[5]), 1'b0, 1'b0, "R12 fill discarded");
    access(vaOf(s[5]), 1'b0, 1'b0, "R12 later hit");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule